// File: doc/BRIEF.md
# Byte-Aliased Dual-Port Register File

This block is a general-purpose register bank for a small 16-bit processor core. It holds eight 16-bit registers and has one write port and two read ports. Each read port has its own select. A single size flag chooses, for the current cycle, between whole-word access and byte access on all three ports.

In byte access, the eight selector codes map onto the four lower-numbered word registers. Codes 0 to 3 reach the low byte of registers 0 to 3. Codes 4 to 7 reach the high byte of registers 0 to 3. A byte write touches only the addressed byte. A byte read returns the byte zero-extended to 16 bits.

Read data is registered and appears one clock after the select is applied. A write at the same clock edge is forwarded into that read data, lane by lane. A synchronous reset clears every register and both read outputs.

Top module: `byte_alias_regfile`

## Requirements
- R1: With `byte_mode`=0, a write stores all 16 bits of `wr_val` in register `wr_sel`, and a read of that register returns all 16 bits.
- R2: With `byte_mode`=1, selector codes 0..3 address bits 7:0 of registers 0..3, and codes 4..7 address bits 15:8 of registers 0..3 (code minus 4). A byte write stores `wr_val[7:0]` into the addressed byte.
- R3: A byte write leaves the other byte of the same register unchanged.
- R4: A byte read returns the addressed byte in bits 7:0 of the read output, with bits 15:8 equal to zero.
- R5: The two read ports decode their selects independently and can return different registers after the same clock edge.
- R6: Each read output is registered. After rising edge N it shows the value selected at edge N. If edge N also writes that register, the read shows the newly written value for each byte lane the write touched, and the old value for the other lane.
- R7: While `rst` is high at a rising edge, every register and both read outputs are cleared to zero. Afterwards every register reads as zero until it is written.
- R8: A register changes only at a rising edge where `wr_en` is 1. While `wr_en` is 0, `wr_val` and `wr_sel` have no effect on any register.
- R9: The single `byte_mode` flag sets the access size of the write port and both read ports in the same cycle. For example, a write with `byte_mode`=1 to code 6 changes only bits 15:8 of register 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| byte_mode | input | 1 | 0 selects 16-bit access, 1 selects byte access, for all ports this cycle |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 3 | Write selector code |
| wr_val | input | 16 | Write data; only bits 7:0 are used in byte access |
| rd_sel_a | input | 3 | Read port A selector code |
| rd_sel_b | input | 3 | Read port B selector code |
| rd_val_a | output | 16 | Registered read data of port A |
| rd_val_b | output | 16 | Registered read data of port B |

## Verification
The assertions check four behaviours on every cycle:
- byte reads always come back zero-extended;
- both outputs sit at zero right after reset;
- a word write is forwarded to a same-select word read on either port;
- a byte write is forwarded to a same-select byte read.

The bench's scenarios cover what needs history:
- that a byte write preserves the neighbouring byte;
- that the high and low byte codes alias the right word registers;
- that a write with the strobe low changes nothing;
- that the two ports return different registers together;
- that a mid-run reset wipes earlier contents.

// File: rtl/rf_pkg.sv
package rf_pkg;

    typedef enum logic {
        SZ_WORD = 1'b0,
        SZ_BYTE = 1'b1
    } access_size_e;

    localparam int RF_READ_PORTS = 2;

endpackage

// File: rtl/rf_lane_decode.sv
module rf_lane_decode
    import rf_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int NUM_REGS = 8,
    localparam int SEL_W   = $clog2(NUM_REGS),
    localparam int LANE_W  = DATA_W / 2
) (
    input  logic                wr_en,
    input  access_size_e        size,
    input  logic [SEL_W-1:0]    wr_sel,
    input  logic [DATA_W-1:0]   wr_val,
    output logic [NUM_REGS-1:0] lo_we,
    output logic [NUM_REGS-1:0] hi_we,
    output logic [LANE_W-1:0]   lo_data,
    output logic [LANE_W-1:0]   hi_data
);

    localparam int HALF = NUM_REGS / 2;

    // Byte writes always take the low byte of the write value.
    always_comb begin
        lo_data = wr_val[LANE_W-1:0];
        hi_data = (size == SZ_BYTE) ? wr_val[LANE_W-1:0] : wr_val[DATA_W-1:LANE_W];
    end

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_lane
        logic word_hit;
        logic byte_lo_hit;
        logic byte_hi_hit;

        always_comb begin
            word_hit    = (wr_sel == SEL_W'(r));
            byte_lo_hit = 1'b0;
            byte_hi_hit = 1'b0;
            if (r < HALF) begin
                byte_lo_hit = (wr_sel == SEL_W'(r));
                byte_hi_hit = (wr_sel == SEL_W'(r + HALF));
            end
        end

        always_comb begin
            unique case (size)
                SZ_WORD: begin
                    lo_we[r] = wr_en && word_hit;
                    hi_we[r] = wr_en && word_hit;
                end
                SZ_BYTE: begin
                    lo_we[r] = wr_en && byte_lo_hit;
                    hi_we[r] = wr_en && byte_hi_hit;
                end
                default: begin
                    lo_we[r] = 1'b0;
                    hi_we[r] = 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/rf_storage.sv
module rf_storage #(
    parameter int DATA_W   = 16,
    parameter int NUM_REGS = 8,
    localparam int LANE_W  = DATA_W / 2
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [NUM_REGS-1:0]              lo_we,
    input  logic [NUM_REGS-1:0]              hi_we,
    input  logic [LANE_W-1:0]                lo_data,
    input  logic [LANE_W-1:0]                hi_data,
    output logic [NUM_REGS-1:0][DATA_W-1:0]  fwd_view
);

    logic [NUM_REGS-1:0][LANE_W-1:0] lo_q;
    logic [NUM_REGS-1:0][LANE_W-1:0] hi_q;

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                lo_q[r] <= '0;
                hi_q[r] <= '0;
            end else begin
                if (lo_we[r]) lo_q[r] <= lo_data;
                if (hi_we[r]) hi_q[r] <= hi_data;
            end
        end

        // View of the register as it stands after this cycle's write.
        always_comb begin
            fwd_view[r][LANE_W-1:0]      = lo_we[r] ? lo_data : lo_q[r];
            fwd_view[r][DATA_W-1:LANE_W] = hi_we[r] ? hi_data : hi_q[r];
        end
    end

endmodule

// File: rtl/rf_read_port.sv
module rf_read_port
    import rf_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int NUM_REGS = 8,
    localparam int SEL_W   = $clog2(NUM_REGS),
    localparam int LANE_W  = DATA_W / 2
) (
    input  logic                            clk,
    input  logic                            rst,
    input  access_size_e                    size,
    input  logic [SEL_W-1:0]                sel,
    input  logic [NUM_REGS-1:0][DATA_W-1:0] view,
    output logic [DATA_W-1:0]               rd_val
);

    logic [SEL_W-1:0]  byte_idx;
    logic              byte_hi;
    logic [DATA_W-1:0] word_pick;
    logic [DATA_W-1:0] rd_nxt;

    always_comb begin
        byte_idx = {1'b0, sel[SEL_W-2:0]};
        byte_hi  = sel[SEL_W-1];
        word_pick = view[byte_idx];
        unique case (size)
            SZ_WORD: rd_nxt = view[sel];
            SZ_BYTE: rd_nxt = byte_hi ? {{LANE_W{1'b0}}, word_pick[DATA_W-1:LANE_W]}
                                      : {{LANE_W{1'b0}}, word_pick[LANE_W-1:0]};
            default: rd_nxt = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) rd_val <= '0;
        else     rd_val <= rd_nxt;
    end

endmodule

// File: rtl/byte_alias_regfile.sv
module byte_alias_regfile
    import rf_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int NUM_REGS = 8,
    localparam int SEL_W   = $clog2(NUM_REGS),
    localparam int LANE_W  = DATA_W / 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_mode,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [DATA_W-1:0] wr_val,
    input  logic [SEL_W-1:0]  rd_sel_a,
    input  logic [SEL_W-1:0]  rd_sel_b,
    output logic [DATA_W-1:0] rd_val_a,
    output logic [DATA_W-1:0] rd_val_b
);

    access_size_e                    size;
    logic [NUM_REGS-1:0]             lo_we;
    logic [NUM_REGS-1:0]             hi_we;
    logic [LANE_W-1:0]               lo_data;
    logic [LANE_W-1:0]               hi_data;
    logic [NUM_REGS-1:0][DATA_W-1:0] fwd_view;

    logic [RF_READ_PORTS-1:0][SEL_W-1:0]  rd_sel_arr;
    logic [RF_READ_PORTS-1:0][DATA_W-1:0] rd_val_arr;

    assign size = byte_mode ? SZ_BYTE : SZ_WORD;

    rf_lane_decode #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) dec_i (
        .wr_en   (wr_en),
        .size    (size),
        .wr_sel  (wr_sel),
        .wr_val  (wr_val),
        .lo_we   (lo_we),
        .hi_we   (hi_we),
        .lo_data (lo_data),
        .hi_data (hi_data)
    );

    rf_storage #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) store_i (
        .clk      (clk),
        .rst      (rst),
        .lo_we    (lo_we),
        .hi_we    (hi_we),
        .lo_data  (lo_data),
        .hi_data  (hi_data),
        .fwd_view (fwd_view)
    );

    assign rd_sel_arr[0] = rd_sel_a;
    assign rd_sel_arr[1] = rd_sel_b;

    for (genvar p = 0; p < RF_READ_PORTS; p++) begin : g_rd
        rf_read_port #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) port_i (
            .clk    (clk),
            .rst    (rst),
            .size   (size),
            .sel    (rd_sel_arr[p]),
            .view   (fwd_view),
            .rd_val (rd_val_arr[p])
        );
    end

    assign rd_val_a = rd_val_arr[0];
    assign rd_val_b = rd_val_arr[1];

endmodule

// File: rtl/rf_checker.sv
module rf_checker #(
    parameter int DATA_W   = 16,
    parameter int NUM_REGS = 8,
    localparam int SEL_W   = $clog2(NUM_REGS),
    localparam int LANE_W  = DATA_W / 2
) (
    input logic              clk,
    input logic              rst,
    input logic              byte_mode,
    input logic              wr_en,
    input logic [SEL_W-1:0]  wr_sel,
    input logic [DATA_W-1:0] wr_val,
    input logic [SEL_W-1:0]  rd_sel_a,
    input logic [SEL_W-1:0]  rd_sel_b,
    input logic [DATA_W-1:0] rd_val_a,
    input logic [DATA_W-1:0] rd_val_b
);

    AST_BYTE_ZEXT_A: assert property (@(posedge clk) disable iff (rst)
        ($past(byte_mode) && !$past(rst)) |-> (rd_val_a[DATA_W-1:LANE_W] == '0)); // R4
    AST_BYTE_ZEXT_B: assert property (@(posedge clk) disable iff (rst)
        ($past(byte_mode) && !$past(rst)) |-> (rd_val_b[DATA_W-1:LANE_W] == '0)); // R4
    AST_RESET_ZERO: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (rd_val_a == '0 && rd_val_b == '0)); // R7
    AST_FWD_WORD_A: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !byte_mode && rd_sel_a == wr_sel) |=> (rd_val_a == $past(wr_val))); // R6
    AST_FWD_WORD_B: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !byte_mode && rd_sel_b == wr_sel) |=> (rd_val_b == $past(wr_val))); // R6
    AST_FWD_BYTE_A: assert property (@(posedge clk) disable iff (rst)
        (wr_en && byte_mode && rd_sel_a == wr_sel)
        |=> (rd_val_a == {{LANE_W{1'b0}}, $past(wr_val[LANE_W-1:0])})); // R2

endmodule

bind byte_alias_regfile rf_checker #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .byte_mode (byte_mode),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_val    (wr_val),
    .rd_sel_a  (rd_sel_a),
    .rd_sel_b  (rd_sel_b),
    .rd_val_a  (rd_val_a),
    .rd_val_b  (rd_val_b)
);

// File: tb/byte_alias_regfile_tb_top.sv
module byte_alias_regfile_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        byte_mode = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [15:0] wr_val = '0;
    logic [2:0]  rd_sel_a = '0;
    logic [2:0]  rd_sel_b = '0;
    logic [15:0] rd_val_a;
    logic [15:0] rd_val_b;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;
    logic [15:0] model [8];

    always #5 clk = ~clk;

    byte_alias_regfile dut_i (
        .clk(clk), .rst(rst), .byte_mode(byte_mode), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_val(wr_val), .rd_sel_a(rd_sel_a), .rd_sel_b(rd_sel_b),
        .rd_val_a(rd_val_a), .rd_val_b(rd_val_b)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [15:0] exp_read(input logic [2:0] sel, input logic bm);
        if (!bm) return model[sel];
        if (sel[2]) return {8'h00, model[{1'b0, sel[1:0]}][15:8]};
        return {8'h00, model[{1'b0, sel[1:0]}][7:0]};
    endfunction

    function automatic void model_write(input logic [2:0] sel, input logic [15:0] v, input logic bm);
        if (!bm) model[sel] = v;
        else if (sel[2]) model[{1'b0, sel[1:0]}][15:8] = v[7:0];
        else model[{1'b0, sel[1:0]}][7:0] = v[7:0];
    endfunction

    task automatic do_write(input logic [2:0] sel, input logic [15:0] v, input logic bm);
        wr_en = 1'b1; wr_sel = sel; wr_val = v; byte_mode = bm;
        step();
        wr_en = 1'b0;
        model_write(sel, v, bm);
    endtask

    task automatic read2(input string tag, input logic [2:0] sa, input logic [2:0] sb, input logic bm);
        rd_sel_a = sa; rd_sel_b = sb; byte_mode = bm; wr_en = 1'b0;
        step();
        check({tag, " port A"}, rd_val_a, exp_read(sa, bm));
        check({tag, " port B"}, rd_val_b, exp_read(sb, bm));
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step(); step();
        rst = 1'b0;
        for (int i = 0; i < 8; i++) model[i] = '0;
    endtask

    // R7: outputs and all registers zero after reset
    task automatic t_reset();
        check("R7 rd_val_a after reset", rd_val_a, 16'h0000);
        check("R7 rd_val_b after reset", rd_val_b, 16'h0000);
        for (int r = 0; r < 8; r++) read2("R7 reg zero", 3'(r), 3'(7 - r), 1'b0);
    endtask

    // R1: full word write and read
    task automatic t_word();
        for (int r = 0; r < 8; r++) do_write(3'(r), 16'(r * 16'h1111) ^ 16'hA50F, 1'b0);
        for (int r = 0; r < 8; r++) read2("R1 word readback", 3'(r), 3'(r), 1'b0);
    endtask

    // R2 R3 R4: byte aliasing, neighbour preserved, zero-extension
    task automatic t_byte();
        for (int r = 0; r < 4; r++) do_write(3'(r), 16'hFFFF, 1'b0);
        for (int s = 0; s < 8; s++) do_write(3'(s), 16'hEE00 | 16'(s * 8'h13), 1'b1);
        for (int s = 0; s < 8; s++) read2("R2 byte alias read", 3'(s), 3'(7 - s), 1'b1);
        for (int r = 0; r < 4; r++) read2("R3 word after byte writes", 3'(r), 3'(r + 4), 1'b0);
        do_write(3'd0, 16'h12FF, 1'b0);
        do_write(3'd0, 16'h5534, 1'b1);
        read2("R3 high byte kept", 3'd0, 3'd4, 1'b0);
        rd_sel_a = 3'd4; rd_sel_b = 3'd0; byte_mode = 1'b1;
        step();
        check("R4 zero-extended high byte", rd_val_a, 16'h0012);
        check("R4 zero-extended low byte", rd_val_b, 16'h0034);
    endtask

    // R5: both ports return different registers together
    task automatic t_dual();
        do_write(3'd5, 16'hDEAD, 1'b0);
        do_write(3'd6, 16'hBEEF, 1'b0);
        rd_sel_a = 3'd6; rd_sel_b = 3'd5; byte_mode = 1'b0;
        step();
        check("R5 port A independent", rd_val_a, 16'hBEEF);
        check("R5 port B independent", rd_val_b, 16'hDEAD);
    endtask

    // R6: registered read with same-edge forwarding per lane
    task automatic t_fwd();
        do_write(3'd1, 16'h1122, 1'b0);
        wr_en = 1'b1; wr_sel = 3'd7; wr_val = 16'h0099; byte_mode = 1'b0;
        rd_sel_a = 3'd7; rd_sel_b = 3'd1;
        step();
        wr_en = 1'b0; model_write(3'd7, 16'h0099, 1'b0);
        check("R6 word forward port A", rd_val_a, 16'h0099);
        check("R6 other reg port B", rd_val_b, 16'h1122);
        wr_en = 1'b1; wr_sel = 3'd5; wr_val = 16'h00C3; byte_mode = 1'b1;
        rd_sel_a = 3'd5; rd_sel_b = 3'd1;
        step();
        wr_en = 1'b0; model_write(3'd5, 16'h00C3, 1'b1);
        check("R6 byte forward high lane", rd_val_a, 16'h00C3);
        check("R6 untouched low lane", rd_val_b, 16'h0022);
        read2("R6 word after lane forward", 3'd1, 3'd7, 1'b0);
    endtask

    // R8: no change with strobe low
    task automatic t_noen();
        wr_en = 1'b0; wr_sel = 3'd7; wr_val = 16'h7777; byte_mode = 1'b0;
        rd_sel_a = 3'd7; rd_sel_b = 3'd7;
        step();
        check("R8 no forward without strobe", rd_val_a, 16'h0099);
        read2("R8 reg unchanged", 3'd7, 3'd2, 1'b0);
    endtask

    // R9: size flag governs the write
    task automatic t_mode();
        do_write(3'd2, 16'h3344, 1'b0);
        do_write(3'd6, 16'hABCD, 1'b1);
        rd_sel_a = 3'd2; rd_sel_b = 3'd6; byte_mode = 1'b0;
        step();
        check("R9 byte write code 6 hits reg2 high", rd_val_a, 16'hCD44);
        check("R9 word read of reg6 untouched", rd_val_b, model[6]);
    endtask

    // R7: mid-run reset wipes contents
    task automatic t_reset_mid();
        do_reset();
        for (int r = 0; r < 8; r += 2) read2("R7 zero after mid reset", 3'(r), 3'(r + 1), 1'b0);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) model[i] = '0;
        @(negedge clk);
        do_reset();
        t_reset();
        t_word();
        t_byte();
        t_dual();
        t_fwd();
        t_noen();
        t_mode();
        t_reset_mid();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

endmodule